// File: doc/BRIEF.md
# Branch Fetch Sequencer

This block owns the program counter of a five-stage in-order pipeline and decides how fetch proceeds around a conditional branch that tests one register against zero. A branch is reported to the sequencer while it sits in the decode stage, together with its kind (taken on zero, or taken on non-zero), its signed offset, whether the tested register is zero, and a hint telling which path the instruction after it was chosen from. The condition takes effect only after a fixed resolution latency of `RESOLVE_CYC` cycles, counted from the decode cycle. It defaults to three.

A two-bit policy input picks one of four behaviours for each branch. Full stall freezes fetch until the outcome is known. Predict-not-taken keeps fetching in sequence and kills the wrong-path work when the branch is taken. Delayed branching always executes the slot instruction that follows the branch. Delayed-canceling does the same but annuls the slot when the branch goes the way the slot was not chosen for. The outputs are the fetch address, a fetch-hold flag marking the current fetch slot as a bubble, a squash pulse that turns younger instructions already fetched into no-ops, and an annul pulse for the delay-slot instruction.

The controller is a three-state machine. Its states are `SQ_RUN` (sequential fetch, branch accepted here), `SQ_HOLD` (waiting for resolution with fetch frozen, used by stall and both delayed policies) and `SQ_SPEC` (waiting for resolution while fetching down the fall-through path). It has these transitions: `SQ_RUN -> SQ_SPEC` when a branch is accepted under predict-not-taken, and `SQ_RUN -> SQ_HOLD` when a branch is accepted under any other policy. `SQ_HOLD -> SQ_RUN` and `SQ_SPEC -> SQ_RUN` happen on the last resolution cycle, when the program counter is loaded with the redirect address. In all other cases a state holds.

Top module: `branch_fetch_seq`

## Requirements
- R1: While reset is held, and in the first cycle after it, `fetch_pc` is 0 and `fetch_hold`, `squash` and `annul` are all low.
- R2: With no branch accepted and no resolution pending, `fetch_pc` grows by 4 every cycle.
- R3: Let B be the branch's own address, so `fetch_pc` equals B+4 in its decode cycle. The target is B+4 plus the sign-extended `br_offset`; for example, a branch at 40 with offset 36 goes to 80. With `br_ne_zero`=0 the branch is taken when `src_is_zero`=1. With `br_ne_zero`=1 it is taken when `src_is_zero`=0.
- R4: Policy 2'b00 (stall): `fetch_hold` is high in the decode cycle and in the two cycles after it, and `fetch_pc` stays at B+4 throughout. In the third cycle after decode, `fetch_pc` is the target if the branch is taken, or B+4 if it is not, and `fetch_hold` is low.
- R5: Policy 2'b01 (predict-not-taken): `fetch_hold` stays low and fetch runs B+4, B+8, B+12. In the third cycle after decode, a taken branch fetches the target with `squash` high for that one cycle. A not-taken branch fetches B+16 with `squash` low.
- R6: Policy 2'b10 (delayed): the slot at B+4 is fetched with `fetch_hold` low in the decode cycle. `fetch_hold` is then high for two cycles. In the third cycle after decode, `fetch_pc` is the target if taken or B+8 if not. `annul` stays low.
- R7: Policy 2'b11 (delayed-canceling) fetches exactly as R6. In addition, `annul` is high for exactly the one cycle after decode when `slot_from_target`=1 and the branch is not taken, or when `slot_from_target`=0 and the branch is taken. Otherwise it stays low.
- R8: The policy is captured in the decode cycle. A change of `policy_sel` while that branch is resolving does not alter its fetch sequence or pulses.
- R9: `br_valid` raised while a branch is still resolving is ignored: that branch's fetch sequence and outcome are unchanged.
- R10: `squash` and `annul` are never high together. `squash` appears only for a predict-not-taken branch, and `annul` only for a delayed-canceling branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| policy_sel | input | 2 | Branch policy: 00 stall, 01 predict-not-taken, 10 delayed, 11 delayed-canceling |
| br_valid | input | 1 | The instruction in decode is a conditional branch |
| br_ne_zero | input | 1 | 0: taken when the register is zero; 1: taken when it is non-zero |
| br_offset | input | OFF_W (16) | Signed branch offset, relative to the branch address plus 4 |
| src_is_zero | input | 1 | Resolved test: the tested register equals zero |
| slot_from_target | input | 1 | Delay slot was filled from the target path (1) or the fall-through path (0) |
| fetch_pc | output | PC_W (32) | Address fetched this cycle |
| fetch_hold | output | 1 | This cycle's fetch slot is a bubble |
| squash | output | 1 | Turn the younger wrong-path instructions into no-ops |
| annul | output | 1 | Cancel the delay-slot instruction now in decode |

## Verification
A wrong state or counter value shows at the ports within one cycle. It appears as `fetch_hold` asserted or missing in a cycle the policy fixes, or as `fetch_pc` failing to step by 4. A corrupted captured redirect address or condition stays hidden until the resolution cycle, three cycles after decode, and then appears as a wrong `fetch_pc` and as a `squash` or `annul` that is missing or spurious. The first sequential step afterwards confirms that the machine has returned to `SQ_RUN`.

// File: rtl/bfs_pkg.sv
package bfs_pkg;

    typedef enum logic [1:0] {
        POL_STALL  = 2'b00,
        POL_PNT    = 2'b01,
        POL_DELAY  = 2'b10,
        POL_CANCEL = 2'b11
    } policy_e;

    typedef enum logic [1:0] {
        SQ_RUN  = 2'b00,
        SQ_HOLD = 2'b01,
        SQ_SPEC = 2'b10
    } seq_state_e;

    typedef enum logic [1:0] {
        PC_STEP = 2'b00,
        PC_KEEP = 2'b01,
        PC_LOAD = 2'b10
    } pc_op_e;

endpackage

// File: rtl/br_decide.sv
module br_decide
    import bfs_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int OFF_W       = 16,
    parameter int RESOLVE_CYC = 3
) (
    input  logic [PC_W-1:0]  cur_pc,
    input  policy_e          policy,
    input  logic             ne_zero,
    input  logic             reg_zero,
    input  logic             fill_target,
    input  logic [OFF_W-1:0] offset,
    output logic             taken,
    output logic [PC_W-1:0]  target,
    output logic [PC_W-1:0]  fall_addr,
    output logic             annul_req
);
    localparam logic [PC_W-1:0] STEP      = PC_W'(4);
    localparam logic [PC_W-1:0] SPEC_SPAN = PC_W'(4 * RESOLVE_CYC);

    logic [PC_W-1:0] off_ext;

    // cur_pc is the address after the branch; the offset is relative to it
    assign off_ext = {{(PC_W-OFF_W){offset[OFF_W-1]}}, offset};
    assign taken   = ne_zero ? !reg_zero : reg_zero;
    assign target  = cur_pc + off_ext;

    always_comb begin
        unique case (policy)
            POL_STALL:  fall_addr = cur_pc;
            POL_PNT:    fall_addr = cur_pc + SPEC_SPAN;
            POL_DELAY,
            POL_CANCEL: fall_addr = cur_pc + STEP;
            default:    fall_addr = cur_pc;
        endcase
    end

    // slot filled from the target is wasted on fall-through, and vice versa
    assign annul_req = fill_target ? !taken : taken;

endmodule

// File: rtl/br_seq_fsm.sv
module br_seq_fsm
    import bfs_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int RESOLVE_CYC = 3
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            br_valid,
    input  policy_e         policy,
    input  logic            taken,
    input  logic [PC_W-1:0] target,
    input  logic [PC_W-1:0] fall_addr,
    input  logic            annul_req,
    output seq_state_e      state,
    output policy_e         pol_q,
    output pc_op_e          pc_op,
    output logic [PC_W-1:0] redirect_pc,
    output logic            hold_out,
    output logic            squash_q,
    output logic            annul_q,
    output logic            last_cyc
);
    localparam int CNT_W = $clog2(RESOLVE_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(RESOLVE_CYC - 1);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    seq_state_e      state_nx;
    logic [CNT_W-1:0] cnt_q;
    logic            accept;

    assign accept   = (state == SQ_RUN) && br_valid;
    assign last_cyc = (state != SQ_RUN) && (cnt_q == CNT_ONE);

    // next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            SQ_RUN:  if (br_valid) state_nx = (policy == POL_PNT) ? SQ_SPEC : SQ_HOLD;
            SQ_HOLD: if (last_cyc) state_nx = SQ_RUN;
            SQ_SPEC: if (last_cyc) state_nx = SQ_RUN;
            default: state_nx = SQ_RUN;
        endcase
    end

    // state register and captured branch context
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= SQ_RUN;
            cnt_q       <= '0;
            pol_q       <= POL_STALL;
            redirect_pc <= '0;
        end else begin
            state <= state_nx;
            if (accept) begin
                cnt_q       <= CNT_LOAD;
                pol_q       <= policy;
                redirect_pc <= taken ? target : fall_addr;
            end else if (state != SQ_RUN) begin
                cnt_q <= cnt_q - CNT_ONE;
            end
        end
    end

    // registered pulses
    logic taken_q;
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_q  <= 1'b0;
            squash_q <= 1'b0;
            annul_q  <= 1'b0;
        end else begin
            if (accept) taken_q <= taken;
            squash_q <= (state == SQ_SPEC) && last_cyc && taken_q;
            annul_q  <= accept && (policy == POL_CANCEL) && annul_req;
        end
    end

    // output decode
    always_comb begin
        pc_op    = PC_STEP;
        hold_out = 1'b0;
        unique case (state)
            SQ_RUN: begin
                if (br_valid && policy != POL_PNT) pc_op = PC_KEEP;
                hold_out = br_valid && (policy == POL_STALL);
            end
            SQ_HOLD: begin
                pc_op    = last_cyc ? PC_LOAD : PC_KEEP;
                hold_out = 1'b1;
            end
            SQ_SPEC: begin
                pc_op    = last_cyc ? PC_LOAD : PC_STEP;
                hold_out = 1'b0;
            end
            default: begin
                pc_op    = PC_STEP;
                hold_out = 1'b0;
            end
        endcase
    end

    AST_SPEC_NO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_SPEC) |-> !hold_out); // R5
    AST_HOLD_STATE_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_HOLD) |=> (state == SQ_RUN) || hold_out); // R4
    AST_ANNUL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        annul_q |=> !annul_q); // R7
    AST_SQUASH_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(squash_q && annul_q)); // R10

endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg
    import bfs_pkg::*;
#(
    parameter int PC_W = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  pc_op_e          op,
    input  logic [PC_W-1:0] load_val,
    output logic [PC_W-1:0] pc
);
    localparam logic [PC_W-1:0] STEP = PC_W'(4);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc <= '0;
        end else begin
            unique case (op)
                PC_STEP: pc <= pc + STEP;
                PC_KEEP: pc <= pc;
                PC_LOAD: pc <= load_val;
                default: pc <= pc;
            endcase
        end
    end

endmodule

// File: rtl/branch_fetch_seq.sv
module branch_fetch_seq
    import bfs_pkg::*;
#(
    parameter int PC_W        = 32,
    parameter int OFF_W       = 16,
    parameter int RESOLVE_CYC = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       policy_sel,
    input  logic             br_valid,
    input  logic             br_ne_zero,
    input  logic [OFF_W-1:0] br_offset,
    input  logic             src_is_zero,
    input  logic             slot_from_target,
    output logic [PC_W-1:0]  fetch_pc,
    output logic             fetch_hold,
    output logic             squash,
    output logic             annul
);
    policy_e         policy;
    policy_e         pol_q;
    seq_state_e      state;
    pc_op_e          pc_op;
    logic            taken;
    logic [PC_W-1:0] target;
    logic [PC_W-1:0] fall_addr;
    logic [PC_W-1:0] redirect_pc;
    logic            annul_req;
    logic            last_cyc;

    assign policy = policy_e'(policy_sel);

    br_decide #(
        .PC_W(PC_W), .OFF_W(OFF_W), .RESOLVE_CYC(RESOLVE_CYC)
    ) u_decide (
        .cur_pc(fetch_pc), .policy(policy), .ne_zero(br_ne_zero),
        .reg_zero(src_is_zero), .fill_target(slot_from_target),
        .offset(br_offset), .taken(taken), .target(target),
        .fall_addr(fall_addr), .annul_req(annul_req)
    );

    br_seq_fsm #(
        .PC_W(PC_W), .RESOLVE_CYC(RESOLVE_CYC)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .br_valid(br_valid), .policy(policy),
        .taken(taken), .target(target), .fall_addr(fall_addr),
        .annul_req(annul_req), .state(state), .pol_q(pol_q), .pc_op(pc_op),
        .redirect_pc(redirect_pc), .hold_out(fetch_hold), .squash_q(squash),
        .annul_q(annul), .last_cyc(last_cyc)
    );

    fetch_pc_reg #(
        .PC_W(PC_W)
    ) u_pc (
        .clk(clk), .rst_n(rst_n), .op(pc_op), .load_val(redirect_pc), .pc(fetch_pc)
    );

    AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == SQ_RUN && !br_valid) |=> fetch_pc == $past(fetch_pc) + PC_W'(4)); // R2
    AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (fetch_hold && !last_cyc) |=> $stable(fetch_pc)); // R4
    AST_SQUASH_PNT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        squash |-> pol_q == POL_PNT); // R10
    AST_ANNUL_CANCEL_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        annul |-> pol_q == POL_CANCEL); // R7

endmodule

// File: tb/branch_fetch_seq_bench.sv
module branch_fetch_seq_bench;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [1:0]  policy_sel;
    logic        br_valid, br_ne_zero, src_is_zero, slot_from_target;
    logic [15:0] br_offset;
    logic [31:0] fetch_pc;
    logic        fetch_hold, squash, annul;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    branch_fetch_seq u_branch_fetch_seq (
        .clk(clk), .rst_n(rst_n), .policy_sel(policy_sel), .br_valid(br_valid),
        .br_ne_zero(br_ne_zero), .br_offset(br_offset), .src_is_zero(src_is_zero),
        .slot_from_target(slot_from_target), .fetch_pc(fetch_pc),
        .fetch_hold(fetch_hold), .squash(squash), .annul(annul)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // one branch; the cycle of decode is t, redirect appears at t+3
    task automatic run_branch(input string req, input logic [1:0] pol, input logic ne,
                              input logic zero, input logic fill, input logic [15:0] off,
                              input bit glitch);
        logic [31:0] b4, tgt, fall, exp_pc;
        bit tk, ann;
        tk   = ne ? !zero : zero;
        ann  = (pol == 2'b11) && (fill ? !tk : tk);
        b4   = fetch_pc;
        tgt  = b4 + {{16{off[15]}}, off};
        fall = (pol == 2'b00) ? b4 : (pol == 2'b01) ? b4 + 32'd12 : b4 + 32'd4;
        policy_sel = pol; br_valid = 1'b1; br_ne_zero = ne;
        src_is_zero = zero; slot_from_target = fill; br_offset = off;
        #1;
        chk(req, "hold in decode cycle", 32'(fetch_hold), 32'(pol == 2'b00));
        @(negedge clk);
        br_valid = 1'b0;
        for (int k = 1; k < 3; k++) begin
            if (glitch && k == 1) begin
                // R8 and R9: new policy and a stray branch during resolution
                policy_sel = ~pol; br_valid = 1'b1; src_is_zero = ~zero;
                #1;
            end
            exp_pc = (pol == 2'b01) ? b4 + 32'(4 * k) : b4;
            chk(req, "pc while resolving", fetch_pc, exp_pc);
            chk(req, "hold while resolving", 32'(fetch_hold), 32'(pol != 2'b01));
            chk(req, "annul while resolving", 32'(annul), 32'(ann && k == 1));
            chk("R10", "squash early", 32'(squash), 32'd0);
            @(negedge clk);
            br_valid = 1'b0; policy_sel = pol; src_is_zero = zero;
        end
        chk(req, "redirect pc", fetch_pc, tk ? tgt : fall);
        chk(req, "hold after resolve", 32'(fetch_hold), 32'd0);
        chk(req, "squash at redirect", 32'(squash), 32'((pol == 2'b01) && tk));
        chk("R10", "annul at redirect", 32'(annul), 32'd0);
        exp_pc = fetch_pc + 32'd4;
        @(negedge clk);
        chk("R2", "step after redirect", fetch_pc, exp_pc);
        chk("R10", "squash one cycle", 32'(squash), 32'd0);
    endtask

    task automatic test_reset();
        @(negedge clk);
        chk("R1", "pc in reset", fetch_pc, 32'd0);
        chk("R1", "hold in reset", 32'(fetch_hold), 32'd0);
        chk("R1", "squash in reset", 32'(squash | annul), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "first pc after reset", fetch_pc, 32'd4);
    endtask

    task automatic test_sequential();
        while (fetch_pc != 32'd44) begin
            logic [31:0] prev;
            prev = fetch_pc;
            @(negedge clk);
            chk("R2", "sequential step", fetch_pc, prev + 32'd4);
        end
    endtask

    initial begin
        rst_n = 1'b0; policy_sel = 2'b00; br_valid = 1'b0; br_ne_zero = 1'b0;
        src_is_zero = 1'b0; slot_from_target = 1'b0; br_offset = '0;
        repeat (2) @(negedge clk);
        test_reset();
        test_sequential();
        run_branch("R3 R4 stall taken 40->80", 2'b00, 1'b0, 1'b1, 1'b0, 16'd36, 1'b0);
        run_branch("R4 stall not taken", 2'b00, 1'b0, 1'b0, 1'b0, 16'd36, 1'b0);
        run_branch("R3 R4 ne-zero taken back", 2'b00, 1'b1, 1'b0, 1'b0, 16'hfff0, 1'b0);
        run_branch("R5 pnt taken", 2'b01, 1'b0, 1'b1, 1'b0, 16'd100, 1'b0);
        run_branch("R5 pnt not taken", 2'b01, 1'b1, 1'b1, 1'b0, 16'd100, 1'b0);
        run_branch("R6 delayed taken", 2'b10, 1'b0, 1'b1, 1'b1, 16'd64, 1'b0);
        run_branch("R6 delayed not taken", 2'b10, 1'b0, 1'b0, 1'b0, 16'd64, 1'b0);
        run_branch("R7 cancel tgt-fill not taken", 2'b11, 1'b0, 1'b0, 1'b1, 16'd8, 1'b0);
        run_branch("R7 cancel tgt-fill taken", 2'b11, 1'b0, 1'b1, 1'b1, 16'd8, 1'b0);
        run_branch("R7 cancel fall-fill taken", 2'b11, 1'b1, 1'b0, 1'b0, 16'd8, 1'b0);
        run_branch("R7 cancel fall-fill not taken", 2'b11, 1'b1, 1'b1, 1'b0, 16'd8, 1'b0);
        run_branch("R8 R9 stall with glitch", 2'b00, 1'b0, 1'b1, 1'b0, 16'd20, 1'b1);
        run_branch("R8 R9 pnt with glitch", 2'b01, 1'b0, 1'b1, 1'b0, 16'd20, 1'b1);
        run_branch("R8 R9 cancel with glitch", 2'b11, 1'b0, 1'b0, 1'b1, 16'd20, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            done = 1'b1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule